// File: doc/BRIEF.md
# Control-Flow Resolver

This unit decides where a 32-bit load-store core fetches next. Each request gives it the program counter of the control-flow instruction, the two source register values, the immediate field the decoder has already pulled out, the destination register index and a 3-bit operation code. It returns whether the transfer is taken, the next program counter, and the return address to write back together with its write enable. There are no condition flags. A conditional branch compares its two source operands directly, and the result depends only on those two values and the chosen relation.

The unit handles three kinds of instruction. Conditional branches use one of six relations. A pc-relative jump-and-link adds a 20-bit displacement to the pc. A register-indirect jump-and-link adds a 12-bit byte offset to the first source operand and then forces the lowest target bit to zero. Offsets for branches and pc-relative jumps count in halfwords, so the unit doubles them before adding. A misaligned-target flag reports a taken target that is not on a 4-byte boundary, but only while short (16-bit) instructions are disabled.

A request is captured on a valid strobe. Its result appears at the outputs one cycle later, qualified by its own valid. Between results the outputs hold their last values.

Top module: `ctrl_flow_resolver`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit clears `res_valid`, `res_taken`, `res_link_we`, `res_misalign`, `res_next_pc`, `res_link` and `res_link_rd` to zero.
- R2: A request with `req_valid` high at a clock edge sets `res_valid` high after that edge, with the result of that request. After an edge where `req_valid` is low, `res_valid` is low and every other output keeps its previous value.
- R3: The operation codes are 0 equal, 1 not equal, 2 signed less-than, 3 signed greater-or-equal, 4 unsigned less-than, 5 unsigned greater-or-equal, 6 pc-relative jump, 7 indirect jump. For codes 0 to 5, `res_taken` is the relation of `req_rs1` against `req_rs2`. For codes 6 and 7, `res_taken` is always 1.
- R4: A taken branch gives `res_next_pc` = pc + 2 × sign-extended `req_imm[11:0]`. Bits 31:12 of `req_imm` have no effect.
- R5: A branch that is not taken gives `res_next_pc` = pc + 4, with `res_link_we` = 0 and `res_link` = 0. A taken branch also has `res_link_we` = 0 and `res_link` = 0.
- R6: Code 6 gives `res_next_pc` = pc + 2 × sign-extended `req_imm[19:0]` and `res_link` = pc + 4. Bits 31:20 of `req_imm` have no effect.
- R7: Code 7 gives `res_next_pc` = (`req_rs1` + sign-extended `req_imm[11:0]`) with bit 0 cleared, and `res_link` = pc + 4. `req_rs2` and bits 31:12 of `req_imm` have no effect.
- R8: `res_link_rd` echoes `req_rd`. `res_link_we` is 1 only for codes 6 and 7 with `req_rd` ≠ 0.
- R9: `res_misalign` is 1 exactly when the transfer is taken, bit 1 of `res_next_pc` is 1, and `req_short_en` was 0 with the request.
- R10: All sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe; inputs are sampled when high |
| req_op | input | 3 | Operation code (see R3) |
| req_pc | input | 32 | Program counter of the instruction |
| req_rs1 | input | 32 | First source operand |
| req_rs2 | input | 32 | Second source operand |
| req_imm | input | 32 | Decoded immediate field |
| req_rd | input | 5 | Destination register index |
| req_short_en | input | 1 | 1 when 16-bit instructions are enabled |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_taken | output | 1 | Transfer taken |
| res_next_pc | output | 32 | Next program counter |
| res_link | output | 32 | Return address (pc + 4) for jumps, 0 for branches |
| res_link_we | output | 1 | Write enable for the return address |
| res_link_rd | output | 5 | Destination index for the return address |
| res_misalign | output | 1 | Taken target not on a 4-byte boundary while short instructions are off |

## Verification
The assertions assume that `rst_n` is synchronous and that request inputs are stable around the sampling edge. They also assume that `req_op` is always a defined 3-bit value, because every one of the eight codes has a meaning and none is treated as illegal. The stimulus changes inputs only on falling edges and keeps every field driven, including while `req_valid` is low. It mixes operand pairs chosen for sign boundaries, equal values and wrap-around with random values, so that every relation sees both outcomes and the checks on hold and ignored bits are exercised at the ports.

// File: rtl/cfr_pkg.sv
// Package: shared operation encoding for the control-flow resolver.
// Assumes the decoder presents one of the eight 3-bit codes below.
package cfr_pkg;

    // Pairs (0/1, 2/3, 4/5) differ only in bit 0, which inverts the relation.
    typedef enum logic [2:0] {
        OP_EQ   = 3'd0,
        OP_NE   = 3'd1,
        OP_LTS  = 3'd2,
        OP_GES  = 3'd3,
        OP_LTU  = 3'd4,
        OP_GEU  = 3'd5,
        OP_JREL = 3'd6,
        OP_JIND = 3'd7
    } cfr_op_e;

    // True for the two jump-and-link codes.
    function automatic logic op_is_jump(cfr_op_e op);
        return op[2] & op[1];
    endfunction

endpackage

// File: rtl/cfr_compare.sv
// Module: cfr_compare
// Evaluates the taken decision from two operands and the operation code.
// Assumes: pure combinational; the jump codes are always taken.
module cfr_compare
    import cfr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cfr_op_e           op,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    output logic              taken
);
    localparam int MSB = XLEN - 1;

    logic [XLEN:0] diff;
    logic          is_eq;
    logic          lt_u;
    logic          lt_s;
    logic          base_rel;

    // One wide subtractor gives both orderings; the borrow is the unsigned result.
    always_comb begin
        diff  = {1'b0, opa} - {1'b0, opb};
        is_eq = (opa == opb);
        lt_u  = diff[XLEN];
        lt_s  = (opa[MSB] ^ opb[MSB]) ? opa[MSB] : lt_u;
    end

    // Select the base relation by the pair, then let bit 0 invert it.
    always_comb begin
        unique case (op[2:1])
            2'b00:   base_rel = is_eq;
            2'b01:   base_rel = lt_s;
            2'b10:   base_rel = lt_u;
            default: base_rel = 1'b1;
        endcase
        taken = op_is_jump(op) ? 1'b1 : (base_rel ^ op[0]);
    end

endmodule

// File: rtl/cfr_target.sv
// Module: cfr_target
// Forms the transfer target and the sequential pc (pc + instruction length).
// Assumes: offsets arrive as raw signed fields inside imm; branch and
// pc-relative offsets count halfwords, the indirect offset counts bytes.
module cfr_target
    import cfr_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int BOFF_W     = 12,
    parameter int JOFF_W     = 20,
    parameter int IOFF_W     = 12,
    parameter int ILEN_BYTES = 4,
    parameter bit SHARED_ADD = 1'b1
) (
    input  cfr_op_e           op,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   rs1,
    input  logic [XLEN-1:0]   imm,
    output logic [XLEN-1:0]   target,
    output logic [XLEN-1:0]   seq_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(ILEN_BYTES);

    logic [XLEN-1:0] br_off;
    logic [XLEN-1:0] jr_off;
    logic [XLEN-1:0] in_off;
    logic [XLEN-1:0] raw_sum;

    // Sign-extend each offset field and scale the halfword ones.
    always_comb begin
        br_off = {{(XLEN-BOFF_W){imm[BOFF_W-1]}}, imm[BOFF_W-1:0]} << 1;
        jr_off = {{(XLEN-JOFF_W){imm[JOFF_W-1]}}, imm[JOFF_W-1:0]} << 1;
        in_off = {{(XLEN-IOFF_W){imm[IOFF_W-1]}}, imm[IOFF_W-1:0]};
    end

    generate
        if (SHARED_ADD) begin : g_shared
            logic [XLEN-1:0] base_sel;
            logic [XLEN-1:0] off_sel;
            // One adder: mux the base and the offset by operation.
            always_comb begin
                base_sel = (op == OP_JIND) ? rs1 : pc;
                unique case (op)
                    OP_JREL: off_sel = jr_off;
                    OP_JIND: off_sel = in_off;
                    default: off_sel = br_off;
                endcase
                raw_sum = base_sel + off_sel;
            end
        end else begin : g_split
            logic [XLEN-1:0] pc_sum;
            logic [XLEN-1:0] rs_sum;
            // Separate adders: the pc path and the register path run in parallel.
            always_comb begin
                pc_sum = pc + ((op == OP_JREL) ? jr_off : br_off);
                rs_sum = rs1 + in_off;
                raw_sum = (op == OP_JIND) ? rs_sum : pc_sum;
            end
        end
    endgenerate

    // Clear bit 0 for the indirect form; produce the fall-through address.
    always_comb begin
        target = (op == OP_JIND) ? {raw_sum[XLEN-1:1], 1'b0} : raw_sum;
        seq_pc = pc + STEP;
    end

endmodule

// File: rtl/ctrl_flow_resolver.sv
// Module: ctrl_flow_resolver (top)
// Resolves branches and jump-and-link instructions for a 32-bit core and
// registers the result one cycle after a request strobe.
// Assumes: synchronous active-low reset; outputs hold between results.
module ctrl_flow_resolver
    import cfr_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int RIDX_W     = 5,
    parameter int BOFF_W     = 12,
    parameter int JOFF_W     = 20,
    parameter int IOFF_W     = 12,
    parameter int ILEN_BYTES = 4,
    parameter bit SHARED_ADD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [XLEN-1:0]   req_pc,
    input  logic [XLEN-1:0]   req_rs1,
    input  logic [XLEN-1:0]   req_rs2,
    input  logic [XLEN-1:0]   req_imm,
    input  logic [RIDX_W-1:0] req_rd,
    input  logic              req_short_en,
    output logic              res_valid,
    output logic              res_taken,
    output logic [XLEN-1:0]   res_next_pc,
    output logic [XLEN-1:0]   res_link,
    output logic              res_link_we,
    output logic [RIDX_W-1:0] res_link_rd,
    output logic              res_misalign
);
    localparam logic [XLEN-1:0] STEP = XLEN'(ILEN_BYTES);

    cfr_op_e           op_e;
    logic              taken_c;
    logic [XLEN-1:0]   target_c;
    logic [XLEN-1:0]   seq_c;
    logic [XLEN-1:0]   next_c;
    logic [XLEN-1:0]   link_c;
    logic              jump_c;
    logic              we_c;
    logic              mis_c;

    // Interpret the raw code as the shared enumeration.
    always_comb op_e = cfr_op_e'(req_op);

    cfr_compare #(.XLEN(XLEN)) u_cmp (
        .op    (op_e),
        .opa   (req_rs1),
        .opb   (req_rs2),
        .taken (taken_c)
    );

    cfr_target #(
        .XLEN       (XLEN),
        .BOFF_W     (BOFF_W),
        .JOFF_W     (JOFF_W),
        .IOFF_W     (IOFF_W),
        .ILEN_BYTES (ILEN_BYTES),
        .SHARED_ADD (SHARED_ADD)
    ) u_tgt (
        .op     (op_e),
        .pc     (req_pc),
        .rs1    (req_rs1),
        .imm    (req_imm),
        .target (target_c),
        .seq_pc (seq_c)
    );

    // Combine the decision, link request and alignment check.
    always_comb begin
        jump_c = op_is_jump(op_e);
        next_c = taken_c ? target_c : seq_c;
        link_c = jump_c ? seq_c : '0;
        we_c   = jump_c && (req_rd != '0);
        mis_c  = taken_c && next_c[1] && !req_short_en;
    end

    // Output stage: capture on a request, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_taken    <= 1'b0;
            res_next_pc  <= '0;
            res_link     <= '0;
            res_link_we  <= 1'b0;
            res_link_rd  <= '0;
            res_misalign <= 1'b0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_taken    <= taken_c;
                res_next_pc  <= next_c;
                res_link     <= link_c;
                res_link_we  <= we_c;
                res_link_rd  <= req_rd;
                res_misalign <= mis_c;
            end
        end
    end

    // R2: a request yields a valid result on the next cycle.
    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R2: without a request the result fields stay put.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid && $stable(res_next_pc) && $stable(res_taken));

    // R5: a branch the comparator rejects falls through with no link write.
    p_fall_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !taken_c |=> res_next_pc == $past(req_pc) + STEP && !res_link_we);

    // R6: pc-relative jump is always taken and links pc + 4.
    p_jrel_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd6 |=> res_taken && res_link == $past(req_pc) + STEP);

    // R7: indirect target is always even.
    p_jind_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd7 |=> res_taken && !res_next_pc[0]);

    // R8: a write request never names register 0 and only follows a taken jump.
    p_no_rd0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_link_we |-> res_link_rd != '0 && res_taken);

    // R9: the misalignment flag needs a taken target with bit 1 set.
    p_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_misalign |-> res_taken && res_next_pc[1]);

endmodule

// File: tb/test_ctrl_flow_resolver.sv
// Self-checking bench: a behavioural model predicts every output each cycle.
module test_ctrl_flow_resolver;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [31:0] req_pc, req_rs1, req_rs2, req_imm;
    logic [4:0]  req_rd;
    logic        req_short_en;
    logic        res_valid, res_taken, res_link_we, res_misalign;
    logic [31:0] res_next_pc, res_link;
    logic [4:0]  res_link_rd;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // expected state
    bit          e_valid, e_taken, e_we, e_mis;
    logic [31:0] e_next, e_link;
    logic [4:0]  e_rd;
    string       e_tag;

    always #4 clk = ~clk;   // 125 MHz

    ctrl_flow_resolver i_ctrl_flow_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_pc(req_pc), .req_rs1(req_rs1), .req_rs2(req_rs2), .req_imm(req_imm),
        .req_rd(req_rd), .req_short_en(req_short_en),
        .res_valid(res_valid), .res_taken(res_taken), .res_next_pc(res_next_pc),
        .res_link(res_link), .res_link_we(res_link_we), .res_link_rd(res_link_rd),
        .res_misalign(res_misalign)
    );

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        string t;
        t = e_valid ? e_tag : "R2";
        cmp("R2", "valid", 32'(res_valid), 32'(e_valid));
        cmp(e_valid ? "R3" : "R2", "taken", 32'(res_taken), 32'(e_taken));
        cmp(t, "next_pc", res_next_pc, e_next);
        cmp(e_valid ? "R5/R6/R7" : "R2", "link", res_link, e_link);
        cmp(e_valid ? "R8" : "R2", "link_we", 32'(res_link_we), 32'(e_we));
        cmp(e_valid ? "R8" : "R2", "link_rd", 32'(res_link_rd), 32'(e_rd));
        cmp(e_valid ? "R9" : "R2", "misalign", 32'(res_misalign), 32'(e_mis));
    endtask

    // Reference behaviour taken from the requirements.
    task automatic predict(bit v, int op, logic [31:0] pc, logic [31:0] a, logic [31:0] b,
                           logic [31:0] imm, logic [4:0] rd, bit sh);
        bit t;
        logic [31:0] tgt;
        int bo, jo, io;
        e_valid = v;
        if (!v) return;
        bo = int'($signed(imm[11:0]));
        jo = int'($signed(imm[19:0]));
        io = int'($signed(imm[11:0]));
        case (op)
            0: t = (a == b);
            1: t = (a != b);
            2: t = ($signed(a) <  $signed(b));
            3: t = ($signed(a) >= $signed(b));
            4: t = (a <  b);
            5: t = (a >= b);
            default: t = 1'b1;
        endcase
        if (op == 6)      tgt = pc + 32'(jo * 2);                      // R6
        else if (op == 7) tgt = (a + 32'(io)) & 32'hFFFF_FFFE;         // R7
        else              tgt = pc + 32'(bo * 2);                      // R4
        e_taken = t;
        e_next  = t ? tgt : pc + 32'd4;                                // R5, R10
        e_link  = (op >= 6) ? pc + 32'd4 : 32'd0;
        e_we    = (op >= 6) && (rd != 0);                              // R8
        e_rd    = rd;
        e_mis   = t && e_next[1] && !sh;                               // R9
        e_tag   = (op == 6) ? "R6" : (op == 7) ? "R7" : t ? "R4" : "R5";
    endtask

    // One cycle: check what the last edge produced, then drive the next request.
    task automatic step(bit v, int op, logic [31:0] pc, logic [31:0] a, logic [31:0] b,
                        logic [31:0] imm, logic [4:0] rd, bit sh);
        @(negedge clk);
        check_all();
        req_valid = v; req_op = 3'(op); req_pc = pc; req_rs1 = a; req_rs2 = b;
        req_imm = imm; req_rd = rd; req_short_en = sh;
        predict(v, op, pc, a, b, imm, rd, sh);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b1; req_op = 3'd6; req_pc = 32'h100;
        req_rs1 = 32'h5; req_rs2 = 32'h5; req_imm = 32'h40; req_rd = 5'd3; req_short_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears every output even with a request present
        e_valid = 0; e_taken = 0; e_next = 0; e_link = 0; e_we = 0; e_rd = 0; e_mis = 0; e_tag = "R1";
        cmp("R1", "valid", 32'(res_valid), 0);
        cmp("R1", "taken", 32'(res_taken), 0);
        cmp("R1", "next_pc", res_next_pc, 0);
        cmp("R1", "link_we", 32'(res_link_we), 0);
        cmp("R1", "misalign", 32'(res_misalign), 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        step(0, 0, 32'h0, 0, 0, 0, 0, 0);
        // R3: each relation, both outcomes, sign boundary operands
        step(1, 0, 32'h1000, 32'h7, 32'h7, 32'h10, 5'd1, 0);
        step(1, 0, 32'h1000, 32'h7, 32'h8, 32'h10, 5'd1, 0);
        step(1, 1, 32'h1000, 32'h7, 32'h8, 32'hFF8, 5'd0, 0);
        step(1, 1, 32'h1000, 32'h9, 32'h9, 32'hFF8, 5'd0, 0);
        step(1, 2, 32'h2000, 32'h8000_0000, 32'h1, 32'h20, 5'd2, 0);
        step(1, 4, 32'h2000, 32'h8000_0000, 32'h1, 32'h20, 5'd2, 0);
        step(1, 3, 32'h2000, 32'hFFFF_FFFF, 32'h0, 32'h20, 5'd2, 0);
        step(1, 5, 32'h2000, 32'hFFFF_FFFF, 32'h0, 32'h20, 5'd2, 0);
        step(1, 3, 32'h2000, 32'h5, 32'h5, 32'h20, 5'd2, 0);
        step(1, 4, 32'h2000, 32'h5, 32'h5, 32'h20, 5'd2, 0);
        // R4: upper immediate bits ignored; negative offset; R10 wrap below zero
        step(1, 0, 32'h3000, 32'h1, 32'h1, 32'hABCD_E800, 5'd4, 0);
        step(1, 0, 32'h0000_0010, 32'h1, 32'h1, 32'h0000_0F00, 5'd4, 0);
        // R9: taken target with bit 1 set, short off then on
        step(1, 0, 32'h4000, 0, 0, 32'h1, 5'd4, 0);
        step(1, 0, 32'h4000, 0, 0, 32'h1, 5'd4, 1);
        // R6: forward, backward, ignored upper bits, rd 0 (R8)
        step(1, 6, 32'h5000, 0, 0, 32'h0008_0000, 5'd1, 0);
        step(1, 6, 32'h5000, 0, 0, 32'hFFF0_0010, 5'd0, 0);
        step(1, 6, 32'hFFFF_FFFC, 0, 0, 32'h2, 5'd31, 0);
        // R7: odd sum cleared, rs2 ignored, upper imm ignored, rd 0
        step(1, 7, 32'h6000, 32'h1235, 32'hDEAD_BEEF, 32'h5555_5000, 5'd9, 1);
        step(1, 7, 32'h6000, 32'h1235, 32'h0, 32'h0000_0FFF, 5'd0, 0);
        step(1, 7, 32'h6000, 32'hFFFF_FFFF, 32'h0, 32'h3, 5'd7, 0);
        // R2: hold with garbage inputs while idle
        step(0, 7, 32'hAAAA_AAAA, 32'h3, 32'h3, 32'h3, 5'd3, 0);
        step(0, 1, 32'h5555_5555, 32'h0, 32'h1, 32'h7, 5'd2, 1);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = ($urandom_range(0, 3) == 0) ? a : $urandom;
            if ($urandom_range(0, 4) == 0) a = {~b[31], a[30:0]};
            step($urandom_range(0, 5) != 0, $urandom_range(0, 7), $urandom, a, b,
                 $urandom, 5'($urandom), $urandom_range(0, 1) == 1);
        end
        step(0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check_all();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule